// File: doc/BRIEF.md
# Selectable Noise Rejection Input Filter

This block conditions one external pin for use as an interrupt source or a timer count source. The pin is brought into the system clock domain by a two-flop synchronizer. An optional inversion is applied next. A digital glitch filter then samples the signal on a prescaled tick, taken every 1, 16 or 64 system cycles, and lets a new level through only when two successive tick samples agree on it. Short disturbances are therefore dropped, and pulses well above the time constant always pass.

The filtered level feeds a detector with two outputs. The first is an interrupt request, whose trigger can be a rising edge, a falling edge, either edge, a high level or a low level. The second is a count strobe for a timer, which pulses once on every rising edge of the filtered signal. Every output is registered. The time constant, the polarity and the trigger are meant to be set while reset is active.

Top module: `pin_event_filter`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `filt_out`, `irq_req` and `cnt_pulse` are all 0.
- R2: With `tc_sel`=0, a level held on `pin_in` shows up on `filt_out` at the fourth rising clock edge after it is applied, and not before.
- R3: With `tc_sel`=0 (time constant 1), a pulse of 2 or more cycles changes `filt_out`, and a pulse of 1 cycle leaves it unchanged.
- R4: With `tc_sel`=1 (time constant 16), a pulse of 32 or more cycles changes `filt_out`, and a pulse of 15 cycles leaves it unchanged.
- R5: With `tc_sel`=2 or 3 (time constant 64), a pulse of 128 or more cycles changes `filt_out`, and a pulse of 63 cycles leaves it unchanged.
- R6: When `invert`=1, the filter works on the complement of the pin, so `filt_out` settles to the inverse of a steady `pin_in`.
- R7: With `trig_sel` 0 (rising), 1 (falling) or 2 (both), `irq_req` is a one-cycle pulse in the cycle after `filt_out` changes in the selected direction.
- R8: With `trig_sel` 3 (high) or 4 (low), `irq_req` equals the matching level of `filt_out` one cycle earlier. This does not apply in the first cycle after reset. With codes 5 to 7, `irq_req` stays 0.
- R9: `cnt_pulse` is a one-cycle pulse in the cycle after each rising edge of `filt_out`, whatever `trig_sel` holds.
- R10: Filter ticks fall on every D-th cycle counted from reset release (D = 1, 16, 64 for `tc_sel` 0, 1, 2/3). `filt_out` changes only at a tick, and only when that tick's sample equals the sample from the previous tick and differs from `filt_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 1 | Asynchronous external pin |
| invert | input | 1 | 1 inverts the pin before filtering |
| tc_sel | input | 2 | Time constant: 0 gives 1, 1 gives 16, 2 and 3 give 64 cycles |
| trig_sel | input | 3 | Trigger: 0 rise, 1 fall, 2 both, 3 high, 4 low, 5-7 none |
| filt_out | output | 1 | Filtered, polarity-adjusted level |
| irq_req | output | 1 | Interrupt request |
| cnt_pulse | output | 1 | One-cycle timer count strobe |

## Verification
In rising and both-edge modes, the interrupt strobe and the count strobe come from the same filtered edge, so they must pulse in the same cycle. In high-level mode, the held request overlaps the count strobe that starts it. The bench provokes these overlaps with directed edge sequences and with random pin runs in every trigger mode. A cycle model of the requirements predicts all three outputs, and the bench compares every cycle against it. A bound checker also requires the rising-mode request to coincide with a count strobe.

// File: rtl/pef_pkg.sv
package pef_pkg;
  // trigger selection codes
  localparam logic [2:0] TRIG_RISE = 3'd0;
  localparam logic [2:0] TRIG_FALL = 3'd1;
  localparam logic [2:0] TRIG_BOTH = 3'd2;
  localparam logic [2:0] TRIG_HIGH = 3'd3;
  localparam logic [2:0] TRIG_LOW  = 3'd4;

  // time constant selection codes
  localparam logic [1:0] TC_SHORT = 2'd0;
  localparam logic [1:0] TC_MID   = 2'd1;
endpackage

// File: rtl/pef_sync.sv
module pef_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[i] <= 1'b0;
        else if (i == 0) chain[i] <= d;
        else chain[i] <= chain[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pef_prescaler.sv
module pef_prescaler
  import pef_pkg::*;
#(
  parameter int MID_DIV  = 16,
  parameter int LONG_DIV = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] tc_sel,
  output logic       tick
);
  localparam int CW = (LONG_DIV > 1) ? $clog2(LONG_DIV) : 1;

  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;

  always_comb begin
    case (tc_sel)
      TC_SHORT: lim = '0;
      TC_MID:   lim = CW'(MID_DIV - 1);
      default:  lim = CW'(LONG_DIV - 1);
    endcase
  end

  assign tick = (cnt >= lim);

  always_ff @(posedge clk) begin
    if (rst)       cnt <= '0;
    else if (tick) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pef_filter.sv
module pef_filter (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic din,
  output logic dout
);
  logic last_samp;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_samp <= 1'b0;
      dout      <= 1'b0;
    end else if (tick) begin
      last_samp <= din;
      if (din == last_samp && din != dout) dout <= din;
    end
  end
endmodule

// File: rtl/pef_detect.sv
module pef_detect
  import pef_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       filt,
  input  logic [2:0] trig_sel,
  output logic       irq,
  output logic       cnt_pulse
);
  logic filt_d;
  logic up, down, req_next;

  assign up   = filt & ~filt_d;
  assign down = ~filt & filt_d;

  always_comb begin
    case (trig_sel)
      TRIG_RISE: req_next = up;
      TRIG_FALL: req_next = down;
      TRIG_BOTH: req_next = up | down;
      TRIG_HIGH: req_next = filt;
      TRIG_LOW:  req_next = ~filt;
      default:   req_next = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      filt_d    <= 1'b0;
      irq       <= 1'b0;
      cnt_pulse <= 1'b0;
    end else begin
      filt_d    <= filt;
      irq       <= req_next;
      cnt_pulse <= up;
    end
  end
endmodule

// File: rtl/pin_event_filter.sv
module pin_event_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int MID_DIV     = 16,
  parameter int LONG_DIV    = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin_in,
  input  logic       invert,
  input  logic [1:0] tc_sel,
  input  logic [2:0] trig_sel,
  output logic       filt_out,
  output logic       irq_req,
  output logic       cnt_pulse
);
  logic pin_s, pol, tick;

  pef_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  assign pol = pin_s ^ invert;

  pef_prescaler #(.MID_DIV(MID_DIV), .LONG_DIV(LONG_DIV)) u_pre (
    .clk(clk), .rst(rst), .tc_sel(tc_sel), .tick(tick)
  );

  pef_filter u_filt (
    .clk(clk), .rst(rst), .tick(tick), .din(pol), .dout(filt_out)
  );

  pef_detect u_det (
    .clk(clk), .rst(rst), .filt(filt_out), .trig_sel(trig_sel),
    .irq(irq_req), .cnt_pulse(cnt_pulse)
  );
endmodule

// File: rtl/pef_checker.sv
module pef_checker (
  input logic       clk,
  input logic       rst,
  input logic [2:0] trig_sel,
  input logic       filt_out,
  input logic       irq_req,
  input logic       cnt_pulse
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!filt_out && !irq_req && !cnt_pulse));

  // R9
  count_rise_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_pulse |-> ($past(filt_out) && !$past(filt_out, 2)));

  // R9
  count_single_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_pulse |=> !cnt_pulse);

  // R7
  rise_match_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_req && $past(trig_sel) == 3'd0) |-> cnt_pulse);

  // R8
  level_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(trig_sel) == 3'd3) |-> (irq_req == $past(filt_out)));

  // R8
  level_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(trig_sel) == 3'd4) |-> (irq_req == !$past(filt_out)));

  // R8
  no_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(trig_sel) > 3'd4) |-> !irq_req);
endmodule

bind pin_event_filter pef_checker u_chk (
  .clk(clk), .rst(rst), .trig_sel(trig_sel),
  .filt_out(filt_out), .irq_req(irq_req), .cnt_pulse(cnt_pulse)
);

// File: tb/pin_event_filter_test.sv
module pin_event_filter_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pin = 1'b0;
  logic inv = 1'b0;
  logic [1:0] tc = 2'd0;
  logic [2:0] trig = 3'd0;
  logic filt_out, irq_req, cnt_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  pin_event_filter uut (
    .clk(clk), .rst(rst), .pin_in(pin), .invert(inv), .tc_sel(tc),
    .trig_sel(trig), .filt_out(filt_out), .irq_req(irq_req), .cnt_pulse(cnt_pulse)
  );

  function automatic int divf(input logic [1:0] t);
    return (t == 2'd0) ? 1 : (t == 2'd1) ? 16 : 64;
  endfunction

  function automatic logic req_of(input logic [2:0] t, input logic f, input logic fd);
    case (t)
      3'd0: return f & ~fd;
      3'd1: return ~f & fd;
      3'd2: return f ^ fd;
      3'd3: return f;
      3'd4: return ~f;
      default: return 1'b0;
    endcase
  endfunction

  // requirement model (R10, R7, R8, R9)
  logic m_s1, m_s2, m_samp, m_filt, m_fd, m_irq, m_cp;
  int   m_cnt;
  always @(posedge clk) begin
    if (rst) begin
      m_s1 <= 0; m_s2 <= 0; m_samp <= 0; m_filt <= 0;
      m_fd <= 0; m_irq <= 0; m_cp <= 0; m_cnt <= 0;
    end else begin
      m_s1 <= pin;
      m_s2 <= m_s1;
      if (m_cnt == divf(tc) - 1) begin
        m_cnt  <= 0;
        m_samp <= m_s2 ^ inv;
        if ((m_s2 ^ inv) == m_samp && (m_s2 ^ inv) != m_filt) m_filt <= m_s2 ^ inv;
      end else m_cnt <= m_cnt + 1;
      m_fd  <= m_filt;
      m_irq <= req_of(trig, m_filt, m_fd);
      m_cp  <= m_filt & ~m_fd;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      checks++;
      if ({filt_out, irq_req, cnt_pulse} !== {m_filt, m_irq, m_cp}) begin
        fails++;
        $display("FAIL R10 model: act filt/irq/cnt=%b%b%b exp=%b%b%b t=%0t",
                 filt_out, irq_req, cnt_pulse, m_filt, m_irq, m_cp, $time);
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [1:0] t_tc, input logic [2:0] t_trig,
                          input logic t_inv, input logic t_pin);
    @(negedge clk);
    rst = 1; tc = t_tc; trig = t_trig; inv = t_inv; pin = t_pin;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic pulse_test(input int width, input bit accept, input string req);
    int d = divf(tc);
    bit seen = 0;
    @(negedge clk);
    pin = 1;
    for (int i = 0; i < width + 4*d + 8; i++) begin
      @(negedge clk);
      if (i == width - 1) pin = 0;
      if (filt_out) seen = 1;
    end
    chk(seen == accept, req, seen, accept);
    chk(filt_out == 1'b0, req, filt_out, 0);
  endtask

  task automatic trig_test(input logic [2:0] mode);
    int ic = 0, cc = 0, hc = 0, exp_i;
    do_reset(2'd0, mode, 1'b0, 1'b0);
    repeat (5) @(negedge clk);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      ic += irq_req; cc += cnt_pulse; hc += filt_out;
      if (i == 0) pin = 1;
      if (i == 8) pin = 0;
    end
    case (mode)
      3'd0, 3'd1: exp_i = 1;
      3'd2: exp_i = 2;
      3'd3: exp_i = 8;
      3'd4: exp_i = 22;
      default: exp_i = 0;
    endcase
    if (mode <= 3'd2) chk(ic == exp_i, "R7 edge request count", ic, exp_i);
    else chk(ic == exp_i, "R8 level request count", ic, exp_i);
    chk(cc == 1, "R9 count strobe per rise", cc, 1);
    chk(hc == 8, "R3 two-cycle level width kept", hc, 8);
  endtask

  initial begin
    void'($urandom(32'd2417));
    // R1 reset state
    do_reset(2'd0, 3'd0, 1'b0, 1'b0);
    chk({filt_out, irq_req, cnt_pulse} == 3'b000, "R1 reset outputs", {filt_out, irq_req, cnt_pulse}, 0);

    // R2 latency with time constant 1
    repeat (4) @(negedge clk);
    pin = 1;
    repeat (3) @(negedge clk);
    chk(filt_out == 1'b0, "R2 not before edge 4", filt_out, 0);
    @(negedge clk);
    chk(filt_out == 1'b1, "R2 at edge 4", filt_out, 1);
    pin = 0;
    repeat (8) @(negedge clk);

    // R3 time constant 1
    pulse_test(1, 0, "R3 one-cycle pulse rejected");
    pulse_test(2, 1, "R3 two-cycle pulse accepted");
    // R4 time constant 16
    do_reset(2'd1, 3'd2, 1'b0, 1'b0);
    pulse_test(15, 0, "R4 15-cycle pulse rejected");
    pulse_test(32, 1, "R4 32-cycle pulse accepted");
    // R5 time constant 64, both codes
    do_reset(2'd2, 3'd0, 1'b0, 1'b0);
    pulse_test(63, 0, "R5 63-cycle pulse rejected");
    pulse_test(128, 1, "R5 128-cycle pulse accepted");
    do_reset(2'd3, 3'd1, 1'b0, 1'b0);
    pulse_test(128, 1, "R5 code 3 pulse accepted");

    // R6 invert
    do_reset(2'd0, 3'd3, 1'b1, 1'b0);
    repeat (10) @(negedge clk);
    chk(filt_out == 1'b1, "R6 inverted low pin", filt_out, 1);
    pin = 1;
    repeat (10) @(negedge clk);
    chk(filt_out == 1'b0, "R6 inverted high pin", filt_out, 0);

    // R7 R8 R9 trigger modes
    for (int m = 0; m < 8; m++) trig_test(3'(m));

    // R10 random runs against the model in every time constant
    for (int t = 0; t < 3; t++) begin
      int d = divf(2'(t));
      int cyc = 0;
      do_reset(2'(t), 3'($urandom % 8), 1'($urandom % 2), 1'b0);
      while (cyc < 2500) begin
        int run = 1 + ($urandom % (3*d));
        pin = 1'($urandom % 2);
        repeat (run) @(negedge clk);
        cyc += run;
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: act=expired exp=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule